// File: doc/BRIEF.md
# Page Map Address Translator

This block turns a virtual address into a physical address. It uses a flat page map that holds one entry for every virtual page. The high bits of the virtual address form the virtual page number (VPN). The VPN indexes the map directly. Each entry holds three fields:

- a resident flag,
- a dirty flag,
- a physical page number (PPN).

When the entry is resident, the physical address is the PPN placed above the untouched page offset. When it is not resident, the block reports a page fault instead of an address. The block also records the faulting VPN and its context, so that an external handler can bring the page in and then acknowledge the fault.

The block keeps two independent maps: a user map and a kernel map. A context-select input on each request picks which map the lookup uses; the kernel map is the one used while an interrupt is being serviced. A store that hits a resident page marks that page dirty.

A handler port works on one map at a time:

- It writes a whole entry (PPN, resident and dirty) in a single cycle.
- It clears a dirty flag on its own.
- It reads any entry back combinationally.

Choosing a victim page and moving data to or from disk are left to the handler.

Top module: `pmt_translator`

## Requirements
- R1: After reset every resident flag and every dirty flag in both maps reads 0, every lookup faults, and no fault is pending.
- R2: Each cycle with `req_valid_i` high produces `rsp_valid_o` high exactly one cycle later. A cycle without a request produces `rsp_valid_o` low one cycle later.
- R3: A lookup whose entry is not resident returns `rsp_fault_o`=1 with `rsp_paddr_o`=0.
- R4: A lookup that hits returns `rsp_fault_o`=0 and `rsp_paddr_o` = {PPN, VA[PAGE_W-1:0]}. The VPN is VA[VA_W-1:PAGE_W].
- R5: `req_kernel_i`=1 selects the kernel map and 0 selects the user map. Handler writes to one map leave the other map unchanged.
- R6: A write lookup that hits sets that entry's dirty flag. A read lookup, or a write lookup that faults, leaves the dirty flag unchanged.
- R7: A cycle with `sw_we_i` high sets the PPN, resident flag and dirty flag of entry `sw_vpn_i` in the map chosen by `sw_kernel_i`. The `sw_rd_*` outputs show the entry at `sw_vpn_i` combinationally.
- R8: `sw_dclr_i` clears only the dirty flag of the addressed entry; the PPN and resident flag are kept.
- R9: When a handler write and a lookup address the same entry of the same map in one cycle, the lookup uses the newly written entry.
- R10: The first fault sets `fault_pending_o` and captures its VPN and context. Later faults leave the captured values unchanged while the fault is pending. `fault_ack_i` clears the pending state, after which the next fault is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup strobe |
| req_write_i | input | 1 | Lookup is a store |
| req_kernel_i | input | 1 | Context select: 1 selects the kernel map |
| req_vaddr_i | input | VA_W | Virtual address |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_fault_o | output | 1 | Page fault |
| rsp_paddr_o | output | PA_W | Physical address; 0 on a fault |
| fault_pending_o | output | 1 | A captured fault awaits acknowledgement |
| fault_kernel_o | output | 1 | Context of the captured fault |
| fault_vpn_o | output | VA_W-PAGE_W | VPN of the captured fault |
| fault_ack_i | input | 1 | Releases the captured fault |
| sw_we_i | input | 1 | Handler entry write |
| sw_dclr_i | input | 1 | Handler dirty clear |
| sw_kernel_i | input | 1 | Handler map select: 1 selects the kernel map |
| sw_vpn_i | input | VA_W-PAGE_W | Handler entry index |
| sw_ppn_i | input | PA_W-PAGE_W | PPN to write |
| sw_res_i | input | 1 | Resident flag to write |
| sw_dirty_i | input | 1 | Dirty flag to write |
| sw_rd_res_o | output | 1 | Resident flag of the addressed entry |
| sw_rd_dirty_o | output | 1 | Dirty flag of the addressed entry |
| sw_rd_ppn_o | output | PA_W-PAGE_W | PPN of the addressed entry |

## Verification
The bench builds the translator with an 8-bit virtual address, 16-address pages and a 7-bit physical address. That gives 16 entries per map and 8 physical pages. At this size every entry of both maps can be programmed with its own arithmetic pattern and then swept at several page offsets. The bench also reads back every resident and dirty flag after reset and after the store and clear sequences. The same-cycle write/lookup collision and the hold-then-acknowledge fault sequence are driven directly at specific entries.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  typedef enum logic {
    CTX_USER   = 1'b0,
    CTX_KERNEL = 1'b1
  } ctx_e;
endpackage

// File: rtl/pmt_map_bank.sv
module pmt_map_bank #(
  parameter int VPN_W = 6,
  parameter int PPN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_res_o,
  output logic [PPN_W-1:0] lk_ppn_o,
  input  logic             set_dirty_i,
  input  logic             we_i,
  input  logic             dclr_i,
  input  logic [VPN_W-1:0] sw_vpn_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic             wr_res_i,
  input  logic             wr_dirty_i,
  output logic             rd_res_o,
  output logic             rd_dirty_o,
  output logic [PPN_W-1:0] rd_ppn_o
);
  localparam int DEPTH = 1 << VPN_W;

  logic [DEPTH-1:0] res_q;
  logic [DEPTH-1:0] dirty_q;
  logic [PPN_W-1:0] ppn_q [DEPTH];
  logic             byp;

  // handler write overrides the stored entry for a colliding lookup
  assign byp      = we_i && (sw_vpn_i == lk_vpn_i);
  assign lk_res_o = byp ? wr_res_i : res_q[lk_vpn_i];
  assign lk_ppn_o = byp ? wr_ppn_i : ppn_q[lk_vpn_i];

  assign rd_res_o   = res_q[sw_vpn_i];
  assign rd_dirty_o = dirty_q[sw_vpn_i];
  assign rd_ppn_o   = ppn_q[sw_vpn_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      dirty_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we_i && sw_vpn_i == VPN_W'(i)) begin
          res_q[i]   <= wr_res_i;
          dirty_q[i] <= wr_dirty_i | (set_dirty_i && lk_vpn_i == VPN_W'(i));
        end else if (set_dirty_i && lk_vpn_i == VPN_W'(i)) begin
          dirty_q[i] <= 1'b1;
        end else if (dclr_i && sw_vpn_i == VPN_W'(i)) begin
          dirty_q[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) ppn_q[sw_vpn_i] <= wr_ppn_i;
  end

  p_wr_res_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> res_q[$past(sw_vpn_i)] == $past(wr_res_i));

  p_store_dirty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_dirty_i |=> dirty_q[$past(lk_vpn_i)]);

  p_clr_keeps_res_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dclr_i && !we_i) |=> res_q[$past(sw_vpn_i)] == $past(res_q[sw_vpn_i]));
endmodule

// File: rtl/pmt_fault_hold.sv
module pmt_fault_hold #(
  parameter int VPN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic             kernel_i,
  input  logic             ack_i,
  output logic             pending_o,
  output logic [VPN_W-1:0] vpn_o,
  output logic             kernel_o
);
  logic             pend_q;
  logic [VPN_W-1:0] vpn_q;
  logic             kern_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      vpn_q  <= '0;
      kern_q <= 1'b0;
    end else if (fault_i && (!pend_q || ack_i)) begin
      pend_q <= 1'b1;
      vpn_q  <= vpn_i;
      kern_q <= kernel_i;
    end else if (ack_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pending_o = pend_q;
  assign vpn_o     = vpn_q;
  assign kernel_o  = kern_q;

  p_hold_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !ack_i) |=> pending_o && $stable(vpn_o) && $stable(kernel_o));
endmodule

// File: rtl/pmt_translator.sv
module pmt_translator
  import pmt_pkg::*;
#(
  parameter int VA_W   = 16,
  parameter int PAGE_W = 10,
  parameter int PA_W   = 14,
  localparam int VPN_W = VA_W - PAGE_W,
  localparam int PPN_W = PA_W - PAGE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             req_kernel_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             fault_pending_o,
  output logic             fault_kernel_o,
  output logic [VPN_W-1:0] fault_vpn_o,
  input  logic             fault_ack_i,
  input  logic             sw_we_i,
  input  logic             sw_dclr_i,
  input  logic             sw_kernel_i,
  input  logic [VPN_W-1:0] sw_vpn_i,
  input  logic [PPN_W-1:0] sw_ppn_i,
  input  logic             sw_res_i,
  input  logic             sw_dirty_i,
  output logic             sw_rd_res_o,
  output logic             sw_rd_dirty_o,
  output logic [PPN_W-1:0] sw_rd_ppn_o
);
  ctx_e             req_ctx;
  logic             sel;
  logic [VPN_W-1:0] vpn;
  logic [PAGE_W-1:0] off;

  logic [1:0]       lk_res;
  logic [PPN_W-1:0] lk_ppn [2];
  logic [1:0]       bank_we, bank_clr, bank_set;
  logic [1:0]       rd_res, rd_dirty;
  logic [PPN_W-1:0] rd_ppn [2];

  logic             hit;
  logic             rsp_valid_q, rsp_fault_q;
  logic [PA_W-1:0]  rsp_paddr_q;

  assign req_ctx = req_kernel_i ? CTX_KERNEL : CTX_USER;
  assign sel     = (req_ctx == CTX_KERNEL);
  assign vpn     = req_vaddr_i[VA_W-1:PAGE_W];
  assign off     = req_vaddr_i[PAGE_W-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_map
    localparam logic G_K = (g == 1);
    assign bank_we[g]  = sw_we_i && (sw_kernel_i == G_K);
    assign bank_clr[g] = sw_dclr_i && (sw_kernel_i == G_K);
    assign bank_set[g] = req_valid_i && req_write_i && (sel == G_K) && lk_res[g];

    pmt_map_bank #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lk_vpn_i    (vpn),
      .lk_res_o    (lk_res[g]),
      .lk_ppn_o    (lk_ppn[g]),
      .set_dirty_i (bank_set[g]),
      .we_i        (bank_we[g]),
      .dclr_i      (bank_clr[g]),
      .sw_vpn_i    (sw_vpn_i),
      .wr_ppn_i    (sw_ppn_i),
      .wr_res_i    (sw_res_i),
      .wr_dirty_i  (sw_dirty_i),
      .rd_res_o    (rd_res[g]),
      .rd_dirty_o  (rd_dirty[g]),
      .rd_ppn_o    (rd_ppn[g])
    );
  end

  assign sw_rd_res_o   = rd_res[sw_kernel_i];
  assign sw_rd_dirty_o = rd_dirty[sw_kernel_i];
  assign sw_rd_ppn_o   = rd_ppn[sw_kernel_i];

  assign hit = lk_res[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_paddr_q <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_fault_q <= req_valid_i && !hit;
      rsp_paddr_q <= (req_valid_i && hit) ? {lk_ppn[sel], off} : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_fault_o = rsp_fault_q;
  assign rsp_paddr_o = rsp_paddr_q;

  pmt_fault_hold #(.VPN_W(VPN_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fault_i   (req_valid_i && !hit),
    .vpn_i     (vpn),
    .kernel_i  (sel),
    .ack_i     (fault_ack_i),
    .pending_o (fault_pending_o),
    .vpn_o     (fault_vpn_o),
    .kernel_o  (fault_kernel_o)
  );

  p_rsp_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_rsp_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !rsp_fault_o);

  p_fault_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_paddr_o == '0);

  p_offset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_fault_o || rsp_paddr_o[PAGE_W-1:0] == $past(off));
endmodule

// File: tb/pmt_translator_bench.sv
`timescale 1ns/1ps
module pmt_translator_bench;
  localparam int VA_W   = 8;
  localparam int PAGE_W = 4;
  localparam int PA_W   = 7;
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int PPN_W  = PA_W - PAGE_W;
  localparam int NV     = 1 << VPN_W;
  localparam int NP     = 1 << PPN_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             req_valid = 0, req_write = 0, req_kernel = 0;
  logic [VA_W-1:0]  req_vaddr = '0;
  logic             rsp_valid, rsp_fault;
  logic [PA_W-1:0]  rsp_paddr;
  logic             f_pend, f_kern;
  logic [VPN_W-1:0] f_vpn;
  logic             f_ack = 0;
  logic             sw_we = 0, sw_dclr = 0, sw_kernel = 0, sw_res = 0, sw_dirty = 0;
  logic [VPN_W-1:0] sw_vpn = '0;
  logic [PPN_W-1:0] sw_ppn = '0;
  logic             rd_res, rd_dirty;
  logic [PPN_W-1:0] rd_ppn;

  int n_chk = 0;
  int n_bad = 0;

  pmt_translator #(.VA_W(VA_W), .PAGE_W(PAGE_W), .PA_W(PA_W)) u_pmt_translator (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_kernel_i(req_kernel),
    .req_vaddr_i(req_vaddr),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr),
    .fault_pending_o(f_pend), .fault_kernel_o(f_kern), .fault_vpn_o(f_vpn),
    .fault_ack_i(f_ack),
    .sw_we_i(sw_we), .sw_dclr_i(sw_dclr), .sw_kernel_i(sw_kernel), .sw_vpn_i(sw_vpn),
    .sw_ppn_i(sw_ppn), .sw_res_i(sw_res), .sw_dirty_i(sw_dirty),
    .sw_rd_res_o(rd_res), .sw_rd_dirty_o(rd_dirty), .sw_rd_ppn_o(rd_ppn)
  );

  function automatic int e_ppn(int k, int v);
    return k ? (v + 5) % NP : (3 * v + 1) % NP;
  endfunction

  function automatic int e_res(int k, int v);
    return k ? int'(v % 2 == 0) : int'(v % 3 != 0);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lookup(int k, int v, int off, bit wr);
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_kernel = k[0];
    req_vaddr  = VA_W'((v << PAGE_W) | off);
    @(negedge clk);
    req_valid  = 1'b0;
    req_write  = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    f_ack = 1'b1;
    @(negedge clk);
    f_ack = 1'b0;
  endtask

  task automatic sw_write(int k, int v, int p, bit r, bit d);
    @(negedge clk);
    sw_we = 1'b1; sw_kernel = k[0]; sw_vpn = VPN_W'(v);
    sw_ppn = PPN_W'(p); sw_res = r; sw_dirty = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic sw_peek(int k, int v);
    sw_kernel = k[0];
    sw_vpn = VPN_W'(v);
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pending after reset", int'(f_pend), 0);
    check("R2 idle rsp_valid", int'(rsp_valid), 0);
    for (int k = 0; k < 2; k++)
      for (int v = 0; v < NV; v++) begin
        sw_peek(k, v);
        check("R1 reset resident", int'(rd_res), 0);
        check("R1 reset dirty", int'(rd_dirty), 0);
      end

    // every lookup faults after reset; first fault captured and held
    for (int k = 0; k < 2; k++)
      for (int v = 0; v < NV; v++) begin
        lookup(k, v, 3, 1'b0);
        check("R1 reset lookup fault", int'(rsp_fault), 1);
        check("R3 fault paddr", int'(rsp_paddr), 0);
        check("R10 held vpn", int'(f_vpn), 0);
        check("R10 held ctx", int'(f_kern), 0);
      end
    check("R10 pending", int'(f_pend), 1);
    ack();
    check("R10 ack clears", int'(f_pend), 0);

    // program both maps
    for (int k = 0; k < 2; k++)
      for (int v = 0; v < NV; v++)
        sw_write(k, v, e_ppn(k, v), e_res(k, v)[0], 1'b0);
    for (int k = 0; k < 2; k++)
      for (int v = 0; v < NV; v++) begin
        sw_peek(k, v);
        check("R7 readback res", int'(rd_res), e_res(k, v));
        check("R7 readback ppn", int'(rd_ppn), e_ppn(k, v));
      end

    // read sweep over both contexts and several offsets
    for (int k = 0; k < 2; k++)
      for (int v = 0; v < NV; v++)
        for (int oi = 0; oi < 3; oi++) begin
          automatic int off = (oi == 0) ? 0 : (oi == 1) ? 5 : 15;
          lookup(k, v, off, 1'b0);
          check("R2 rsp_valid", int'(rsp_valid), 1);
          check(k ? "R5 kernel fault" : "R3 user fault", int'(rsp_fault), 1 - e_res(k, v));
          check(k ? "R5 kernel paddr" : "R4 user paddr", int'(rsp_paddr),
                e_res(k, v) ? ((e_ppn(k, v) << PAGE_W) | off) : 0);
        end
    @(negedge clk);
    check("R2 rsp drops", int'(rsp_valid), 0);
    ack();
    for (int k = 0; k < 2; k++)
      for (int v = 0; v < NV; v++) begin
        sw_peek(k, v);
        check("R6 reads leave dirty", int'(rd_dirty), 0);
      end

    // stores
    lookup(0, 1, 2, 1'b1);
    lookup(0, 3, 2, 1'b1);
    lookup(1, 1, 2, 1'b1);
    lookup(1, 2, 2, 1'b1);
    ack();
    sw_peek(0, 1); check("R6 store hit dirty", int'(rd_dirty), 1);
    sw_peek(0, 3); check("R6 store fault no dirty", int'(rd_dirty), 0);
    sw_peek(1, 1); check("R6 store fault no dirty", int'(rd_dirty), 0);
    sw_peek(1, 2); check("R6 kernel store dirty", int'(rd_dirty), 1);
    sw_peek(0, 2); check("R5 other map untouched", int'(rd_dirty), 0);

    // dirty clear
    @(negedge clk);
    sw_dclr = 1'b1; sw_kernel = 1'b0; sw_vpn = VPN_W'(1);
    @(negedge clk);
    sw_dclr = 1'b0;
    sw_peek(0, 1);
    check("R8 dirty cleared", int'(rd_dirty), 0);
    check("R8 res kept", int'(rd_res), 1);
    check("R8 ppn kept", int'(rd_ppn), e_ppn(0, 1));
    sw_peek(1, 2);
    check("R8 kernel dirty kept", int'(rd_dirty), 1);

    // same-cycle handler write and lookup to user vpn 3
    @(negedge clk);
    sw_we = 1'b1; sw_kernel = 1'b0; sw_vpn = VPN_W'(3);
    sw_ppn = PPN_W'(6); sw_res = 1'b1; sw_dirty = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_kernel = 1'b0;
    req_vaddr = VA_W'((3 << PAGE_W) | 7);
    @(negedge clk);
    sw_we = 1'b0; req_valid = 1'b0;
    check("R9 bypass fault", int'(rsp_fault), 0);
    check("R9 bypass paddr", int'(rsp_paddr), (6 << PAGE_W) | 7);
    sw_peek(0, 3);
    check("R9 entry written", int'(rd_ppn), 6);

    // fault capture sequence
    check("R10 idle", int'(f_pend), 0);
    lookup(1, 3, 0, 1'b0);
    check("R10 capture pend", int'(f_pend), 1);
    check("R10 capture vpn", int'(f_vpn), 3);
    check("R10 capture ctx", int'(f_kern), 1);
    lookup(0, 6, 0, 1'b0);
    check("R10 second ignored vpn", int'(f_vpn), 3);
    check("R10 second ignored ctx", int'(f_kern), 1);
    ack();
    check("R10 ack", int'(f_pend), 0);
    lookup(0, 6, 0, 1'b0);
    check("R10 recapture vpn", int'(f_vpn), 6);
    check("R10 recapture ctx", int'(f_kern), 0);
    check("R10 recapture pend", int'(f_pend), 1);

    finish_run();
  end
endmodule